// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block computes a short FIR filter without any hardware multiplier. Each accepted signed sample enters a tap delay line. The block then walks through the sample bits one per clock cycle, starting at the least significant bit. In every cycle it takes the current bit of every tap and uses these bits together as an address into a small constant table. Each table entry holds the sum of the coefficients selected by that address. A shift-and-add accumulator weights each table word by its bit position. It subtracts the word read for the two's-complement sign bit, so that signed samples come out right.

A producer presents a sample with a one-cycle valid strobe whenever the busy flag is low. After one pass over the sample bits, the filter output appears together with a one-cycle done strobe. The output then holds its value until the next done strobe. The coefficients are integer parameters, and the table with 2^taps entries is built from them at elaboration.

Top module: `daFir`

## Requirements
- R1: After reset, inBusy and outDone are 0, outResult is 0 and every tap of the delay line holds 0.
- R2: A sample is accepted on a rising edge where inValid is 1 and inBusy is 0; inBusy reads 1 from that edge until the computation ends.
- R3: inValid asserted while inBusy is 1 has no effect: neither the current result nor the contents of the delay line change.
- R4: outDone is a single-cycle pulse that rises exactly SAMPLE_W clock cycles after the accepting edge, on the same edge on which inBusy falls; inBusy never stays high for more than SAMPLE_W cycles in a row.
- R5: outResult equals the full-precision signed sum over k of COEFS[k] times tap k, where tap 0 is the newest accepted sample and tap NUM_TAPS-1 the oldest.
- R6: Samples and coefficients are two's complement; the most negative sample value (-2^(SAMPLE_W-1)) gives the exact product, because the sign-bit table word carries negative weight.
- R7: outResult changes only on the edge that raises outDone and is stable at all other times.
- R8: Each accepted sample moves every tap one place toward the oldest position and drops the oldest, so a single 1 followed by zeros outputs COEFS[0], COEFS[1], ... in turn.
- R9: A new sample may be accepted on the edge right after the done pulse appears, giving one result every SAMPLE_W+1 cycles at full rate.
- R10: The result width is COEF_W + clog2(NUM_TAPS) + SAMPLE_W bits, so no combination of in-range samples and coefficients (values within COEF_W signed bits) overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe, taken only while inBusy is 0 |
| inSample | input | SAMPLE_W | Signed input sample |
| inBusy | output | 1 | High while a bit-serial pass is running |
| outDone | output | 1 | One-cycle pulse marking a new result |
| outResult | output | COEF_W+clog2(NUM_TAPS)+SAMPLE_W | Signed filter output, held between pulses |

## Verification
An impulse followed by zeros reads the coefficients back one tap at a time, which shows whether the delay line order and the table addressing are right. Runs of the most negative and most positive sample separate a correct sign-bit subtraction from a plain add, and they push the accumulator to its widest values. A long stream of random signed samples is compared with a direct multiply-accumulate model and covers general table addresses and carry patterns. Strobes pulsed while the filter is busy, and samples offered right at the done pulse, show that the handshake neither drops nor corrupts delay-line state.

// File: rtl/daFirPkg.sv
package daFirPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture a new sample into the delay line
    logic step;   // consume one bit slice
    logic last;   // this slice is the sign bit
  } ctrlStrobe_t;

endpackage

// File: rtl/daFirLut.sv
module daFirLut #(
  parameter int NUM_TAPS = 4,
  parameter int LUT_W    = 10,
  parameter int COEFS [NUM_TAPS] = '{default: 0}
) (
  input  logic [NUM_TAPS-1:0]     addr,
  output logic signed [LUT_W-1:0] sum
);

  localparam int DEPTH = 1 << NUM_TAPS;

  // Sum of the coefficients whose select bit is set
  function automatic logic signed [LUT_W-1:0] subsetSum(input int unsigned sel);
    logic signed [LUT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (sel[k]) acc = acc + LUT_W'(COEFS[k]);
    end
    return acc;
  endfunction

  logic signed [LUT_W-1:0] romData [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign romData[a] = subsetSum(a);
  end

  assign sum = romData[addr];

endmodule

// File: rtl/daFirDatapath.sv
module daFirDatapath
  import daFirPkg::*;
#(
  parameter int NUM_TAPS = 4,
  parameter int SAMPLE_W = 8,
  parameter int LUT_W    = 10,
  parameter int ACC_W    = 18,
  parameter int IDX_W    = 3,
  parameter int COEFS [NUM_TAPS] = '{default: 0}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [IDX_W-1:0]           bitIdx,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic signed [ACC_W-1:0]    result
);

  logic signed [SAMPLE_W-1:0] tapReg   [NUM_TAPS];
  logic [SAMPLE_W-1:0]        bitShift [NUM_TAPS];
  logic [NUM_TAPS-1:0]        sliceAddr;
  logic signed [LUT_W-1:0]    lutSum;
  logic signed [ACC_W-1:0]    term;
  logic signed [ACC_W-1:0]    acc;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign sliceAddr[k] = bitShift[k][0];
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tapReg[k]   <= '0;
          bitShift[k] <= '0;
        end else if (strobe.load) begin
          tapReg[k]   <= inSample;
          bitShift[k] <= inSample;
        end else if (strobe.step) begin
          bitShift[k] <= bitShift[k] >> 1;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tapReg[k]   <= '0;
          bitShift[k] <= '0;
        end else if (strobe.load) begin
          tapReg[k]   <= tapReg[k-1];
          bitShift[k] <= tapReg[k-1];
        end else if (strobe.step) begin
          bitShift[k] <= bitShift[k] >> 1;
        end
      end
    end
  end

  daFirLut #(
    .NUM_TAPS(NUM_TAPS),
    .LUT_W   (LUT_W),
    .COEFS   (COEFS)
  ) i_lut (
    .addr(sliceAddr),
    .sum (lutSum)
  );

  // Table word weighted by the bit position of the current slice
  assign term = ACC_W'(lutSum) <<< bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
    end else if (strobe.load) begin
      acc <= '0;
    end else if (strobe.step) begin
      if (strobe.last) begin
        result <= acc - term;   // sign bit carries negative weight
        acc    <= '0;
      end else begin
        acc <= acc + term;
      end
    end
  end

endmodule

// File: rtl/daFirCtrl.sv
module daFirCtrl
  import daFirPkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             busy,
  output logic             done,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] bitIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLE_W - 1);

  always_comb begin
    strobe.load = inValid && !busy;
    strobe.step = busy;
    strobe.last = busy && (bitIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitIdx <= '0;
    end else begin
      done <= strobe.last;
      if (strobe.load) begin
        busy   <= 1'b1;
        bitIdx <= '0;
      end else if (strobe.step) begin
        if (strobe.last) begin
          busy   <= 1'b0;
          bitIdx <= '0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/daFir.sv
module daFir
  import daFirPkg::*;
#(
  parameter int NUM_TAPS = 4,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int COEFS [NUM_TAPS] = '{12, -7, 100, -128},
  localparam int LUT_W   = COEF_W + $clog2(NUM_TAPS),
  localparam int ACC_W   = LUT_W + SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic                       inBusy,
  output logic                       outDone,
  output logic signed [ACC_W-1:0]    outResult
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] bitIdx;

  daFirCtrl #(
    .SAMPLE_W(SAMPLE_W),
    .IDX_W   (IDX_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .busy   (inBusy),
    .done   (outDone),
    .strobe (strobe),
    .bitIdx (bitIdx)
  );

  daFirDatapath #(
    .NUM_TAPS(NUM_TAPS),
    .SAMPLE_W(SAMPLE_W),
    .LUT_W   (LUT_W),
    .ACC_W   (ACC_W),
    .IDX_W   (IDX_W),
    .COEFS   (COEFS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .inSample(inSample),
    .result  (outResult)
  );

endmodule

// File: rtl/daFirChecker.sv
module daFirChecker #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 18
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inBusy,
  input logic                    outDone,
  input logic signed [ACC_W-1:0] outResult
);

  int busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= 0;
    else if (inBusy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inBusy) |=> inBusy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outDone) |-> ($fell(inBusy) || (inBusy && $past(inValid)))); // R4

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    inBusy |-> (busyCnt < SAMPLE_W)); // R4

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !outDone |-> $stable(outResult)); // R7

endmodule

bind daFir daFirChecker #(
  .SAMPLE_W(SAMPLE_W),
  .ACC_W   (ACC_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inBusy   (inBusy),
  .outDone  (outDone),
  .outResult(outResult)
);

// File: tb/test_daFir.sv
`timescale 1ns/1ps
module test_daFir;

  localparam int TAPS = 4;
  localparam int SW   = 8;
  localparam int CW   = 8;
  localparam int AW   = CW + $clog2(TAPS) + SW;
  localparam int BENCH_COEFS [TAPS] = '{12, -7, 100, -128};

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [SW-1:0] inSample = '0;
  logic                 inBusy;
  logic                 outDone;
  logic signed [AW-1:0] outResult;

  int checks = 0;
  int errors = 0;
  int hist [TAPS];

  always #2.5 clk = ~clk;

  daFir #(
    .NUM_TAPS(TAPS),
    .SAMPLE_W(SW),
    .COEF_W  (CW),
    .COEFS   (BENCH_COEFS)
  ) i_daFir (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSample (inSample),
    .inBusy   (inBusy),
    .outDone  (outDone),
    .outResult(outResult)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int modelOut();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += BENCH_COEFS[k] * hist[k];
    return s;
  endfunction

  // Send one sample and check its result. fast=1: caller stands at the
  // done negedge and wants the sample taken on the very next edge.
  task automatic sendSample(input int val, input int disturbAt, input string req, input bit fast);
    int lat;
    int res;
    if (!fast) begin
      @(negedge clk);
      while (inBusy) @(negedge clk);
    end
    inValid  = 1'b1;
    inSample = SW'(val);
    @(negedge clk);
    inValid = 1'b0;
    check(inBusy == 1'b1, "R2 busy after accept", int'(inBusy), 1);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = val;
    lat = 0;
    while (!outDone && lat < 40) begin
      inValid  = (lat == disturbAt);
      inSample = SW'(val ^ 8'h5a);
      @(negedge clk);
      lat++;
    end
    inValid = 1'b0;
    check(lat == SW, "R4 done latency", lat, SW);
    check(!inBusy, "R4 busy low at done", int'(inBusy), 0);
    check(int'(outResult) == modelOut(), req, int'(outResult), modelOut());
    if (!fast) begin
      res = int'(outResult);
      @(negedge clk);
      check(!outDone, "R4 done one cycle", int'(outDone), 0);
      check(int'(outResult) == res, "R7 result held", int'(outResult), res);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!inBusy, "R1 busy reset", int'(inBusy), 0);
    check(!outDone, "R1 done reset", int'(outDone), 0);
    check(outResult == '0, "R1 result reset", int'(outResult), 0);
  endtask

  task automatic testImpulse();
    // R1: a cleared delay line means the first result is COEFS[0] alone
    // R8: the impulse walks through the taps
    sendSample(1, -1, "R1 R8 impulse tap0", 1'b0);
    for (int i = 1; i <= TAPS; i++) sendSample(0, -1, "R8 impulse walk", 1'b0);
  endtask

  task automatic testExtremes();
    for (int i = 0; i < TAPS; i++) sendSample(-128, -1, "R6 most negative run", 1'b0);
    for (int i = 0; i < TAPS; i++) sendSample(127, -1, "R6 R10 most positive run", 1'b0);
    for (int i = 0; i < TAPS; i++) sendSample((i % 2 == 0) ? -128 : 127, -1, "R6 alternating", 1'b0);
    sendSample(-1, -1, "R6 minus one", 1'b0);
  endtask

  task automatic testIgnoreBusy();
    // R3: strobes mid-pass must change neither result nor delay line
    sendSample(45, 2, "R3 strobe while busy", 1'b0);
    sendSample(-77, 6, "R3 strobe late in pass", 1'b0);
    sendSample(3, -1, "R3 delay line untouched", 1'b0);
  endtask

  task automatic testBackToBack();
    sendSample(19, -1, "R9 first", 1'b0);
    while (inBusy) @(negedge clk);
    sendSample(-100, -1, "R9 lead", 1'b0);
    for (int i = 0; i < 3; i++) sendSample(i * 40 - 60, -1, "R9 back to back", 1'b1);
    @(negedge clk);
    check(!outDone, "R4 done one cycle", int'(outDone), 0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) begin
      int v;
      v = int'($signed(SW'($urandom)));
      sendSample(v, -1, "R5 random", 1'b0);
    end
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testImpulse();
    testExtremes();
    testIgnoreBusy();
    testBackToBack();
    testRandom();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule